// File: doc/BRIEF.md
# Graphics Command FIFO with Object-Checking Puller

This block takes graphics commands from a simple register bus and delivers them, in order, to a dispatch port. Each command takes two bus writes into a command window. The first is a method word that carries a method offset and a subchannel. The second is a data word that carries the object name. The data word completes an entry, which is pushed into a small circular command cache. The slot number is converted to Gray code before it addresses entry storage.

A puller drains the cache one entry at a time, and only while its enable flag is set. For the entry at the head it asks an external object lookup for the object name and receives a hit flag and a 32-bit context word. If the lookup misses, or if it returns an object of software class (context bit 23 clear), the puller clears its own enable, records the cause in its control register and raises a sticky cache-error interrupt. The entry stays at the head until software re-enables the puller. A hardware-class object is handed on through a valid/ready pair, together with its context word.

Register offsets on the 8-bit byte address: 0x00 pull control, 0x04 push access, 0x08 puller context state, 0x0C status, 0x10 put pointer, 0x14 get pointer. The command window is 0x40 to 0x7F.

Top module: `cmdfifo_top`

## Requirements
- R1: In the command window, a write with address bit 2 clear is a method word. It keeps `wdata & 0x1FFC` as the method offset and `wdata[15:13]` as the subchannel. A write with bit 2 set is the data word, which completes the entry. The dispatch port presents these three values unchanged.
- R2: Entries leave in the order they entered. The put and get registers read the binary entry counts (modulo DEPTH) in bits 6:2.
- R3: Empty (status bit 4) means get equals put. Full (status bit 5) means the next put would equal get, so DEPTH-1 entries fit. A data word written while the cache is full is dropped, leaves the put pointer unchanged and sets overflow (status bit 2).
- R4: Push access is bit 0 at 0x04 and resets to 0. A data word written while it is clear is dropped and sets no-cache (status bit 3).
- R5: The puller makes no lookup and dispatches nothing while enable (pull control bit 0) is clear or the cache is empty.
- R6: A lookup miss sets hash-failure (bit 4), clears enable and sets error-pending (status bit 1) and the interrupt (status bit 0). The entry is not dispatched.
- R7: A hit whose context bit 23 is clear sets software-method (bit 8) and clears hash-failure and enable. It raises the interrupt and dispatches nothing.
- R8: A hit whose context bit 23 is set clears hash-failure and software-method and dispatches the entry. `disp_valid` and the payload hold steady until `disp_ready`.
- R9: The `irq` output follows status bit 0, which stays set until a status write with a one in that bit. Status bits 3:0 are each cleared by writing one.
- R10: The dirty flag at bit 4 of 0x08 can be written and read back. The other bits of 0x08 read as zero.
- R11: A write to pull control affects only enable (bit 0) and hash-failure (bit 4). Software-method (bit 8) is unaffected by writes.
- R12: After reset, pull control, push access and status flags are zero, status reads 0x10, `irq` and `disp_valid` are low, and both pointers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lookup_valid | output | 1 | Puller is asking about the head entry this cycle |
| lookup_name | output | 32 | Object name of the head entry |
| lookup_subch | output | 3 | Subchannel of the head entry |
| lookup_hit | input | 1 | Object was found |
| lookup_ctx | input | 32 | Context word of the object; bit 23 set marks hardware class |
| disp_valid | output | 1 | Dispatch entry is valid |
| disp_ready | input | 1 | Dispatch side accepts the entry |
| disp_subch | output | 3 | Dispatched subchannel |
| disp_method | output | 13 | Dispatched method offset |
| disp_data | output | 32 | Dispatched object name |
| disp_ctx | output | 32 | Context word of the dispatched object |
| irq | output | 1 | Sticky cache-error interrupt |

## Verification
The bench fills the cache to DEPTH-1 entries and then writes one more entry. A design with an off-by-one full test would overwrite the oldest entry, and the drain would show a lost entry or a foreign one. Miss and software-class objects are each presented to the puller. A design that failed to halt would dispatch them or keep raising lookups, and one that set the wrong flag would read back a wrong pull-control value. A write of bit 4 and bit 8 during a software halt catches control writes that reach bit 8. Backpressure and a partial status clear catch a payload that changes before acceptance and an interrupt that drops too early.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;

    localparam int BUS_AW  = 8;
    localparam int WORD_W  = 32;
    localparam int METH_W  = 13;
    localparam int SUBCH_W = 3;

    localparam logic [BUS_AW-1:0] REG_PULL_CTRL = 8'h00;
    localparam logic [BUS_AW-1:0] REG_PUSH_EN   = 8'h04;
    localparam logic [BUS_AW-1:0] REG_CTX_STATE = 8'h08;
    localparam logic [BUS_AW-1:0] REG_STATUS    = 8'h0C;
    localparam logic [BUS_AW-1:0] REG_PUT       = 8'h10;
    localparam logic [BUS_AW-1:0] REG_GET       = 8'h14;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_HASH_BIT = 4;
    localparam int CTRL_SW_BIT   = 8;
    localparam int DIRTY_BIT     = 4;
    localparam int HW_CLASS_BIT  = 23;
    localparam logic [METH_W-1:0] METH_MASK = 13'h1FFC;

    typedef struct packed {
        logic [SUBCH_W-1:0] subch;
        logic [METH_W-1:0]  method;
        logic [WORD_W-1:0]  data;
    } cmd_entry_t;

    typedef struct packed {
        logic sw;
        logic hash;
        logic en;
    } pull_ctrl_t;

    typedef enum logic [1:0] {
        STS_IRQ     = 2'd0,
        STS_ERR     = 2'd1,
        STS_OVF     = 2'd2,
        STS_NOCACHE = 2'd3
    } sts_bit_e;

    function automatic logic in_cmd_window(input logic [BUS_AW-1:0] a);
        return a[7:6] == 2'b01;
    endfunction

endpackage

// File: rtl/cf_cmd_store.sv
module cf_cmd_store
    import cmdfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  cmd_entry_t       wr_entry,
    input  logic             rd_pop,
    output cmd_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic [PTR_W-1:0] put_ptr,
    output logic [PTR_W-1:0] get_ptr
);

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    cmd_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] put_q, get_q;
    logic [PTR_W-1:0] put_idx, get_idx;

    assign put_idx = to_gray(put_q);
    assign get_idx = to_gray(get_q);

    assign empty   = (put_q == get_q);
    assign full    = (PTR_W'(put_q + 1'b1) == get_q);
    assign head    = slots[get_idx];
    assign put_ptr = put_q;
    assign get_ptr = get_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            put_q <= '0;
            get_q <= '0;
        end else begin
            if (wr_en && !full) put_q <= PTR_W'(put_q + 1'b1);
            if (rd_pop && !empty) get_q <= PTR_W'(get_q + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) slots[put_idx] <= wr_entry;
    end

endmodule

// File: rtl/cf_puller.sv
module cf_puller
    import cmdfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              ctrl_en_wr,
    input  logic              ctrl_hash_wr,
    input  cmd_entry_t        head,
    input  logic              empty,
    input  logic              lookup_hit,
    input  logic [WORD_W-1:0] lookup_ctx,
    input  logic              disp_ready,
    output pull_ctrl_t        ctrl_q,
    output logic              lookup_valid,
    output logic              pop,
    output logic              evt_miss,
    output logic              evt_sw,
    output logic              disp_valid,
    output cmd_entry_t        disp_entry,
    output logic [WORD_W-1:0] disp_ctx
);

    pull_ctrl_t ctrl_d;
    logic       attempt;
    logic       is_hw;

    assign attempt      = ctrl_q.en && !empty && (!disp_valid || disp_ready);
    assign is_hw        = lookup_hit && lookup_ctx[HW_CLASS_BIT];
    assign lookup_valid = attempt;
    assign pop          = attempt && is_hw;
    assign evt_miss     = attempt && !lookup_hit;
    assign evt_sw       = attempt && lookup_hit && !lookup_ctx[HW_CLASS_BIT];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.en   = ctrl_en_wr;
            ctrl_d.hash = ctrl_hash_wr;
        end
        if (attempt) begin
            if (!lookup_hit) begin
                ctrl_d.hash = 1'b1;
                ctrl_d.en   = 1'b0;
            end else begin
                ctrl_d.hash = 1'b0;
                if (!lookup_ctx[HW_CLASS_BIT]) begin
                    ctrl_d.sw = 1'b1;
                    ctrl_d.en = 1'b0;
                end else begin
                    ctrl_d.sw = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            disp_valid <= 1'b0;
            disp_entry <= '0;
            disp_ctx   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (pop) begin
                disp_valid <= 1'b1;
                disp_entry <= head;
                disp_ctx   <= lookup_ctx;
            end else if (disp_ready) begin
                disp_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmdfifo_top.sv
module cmdfifo_top
    import cmdfifo_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               lookup_valid,
    output logic [WORD_W-1:0]  lookup_name,
    output logic [SUBCH_W-1:0] lookup_subch,
    input  logic               lookup_hit,
    input  logic [WORD_W-1:0]  lookup_ctx,
    output logic               disp_valid,
    input  logic               disp_ready,
    output logic [SUBCH_W-1:0] disp_subch,
    output logic [METH_W-1:0]  disp_method,
    output logic [WORD_W-1:0]  disp_data,
    output logic [WORD_W-1:0]  disp_ctx,
    output logic               irq
);

    localparam int PTR_W = $clog2(DEPTH);

    logic               push_en_q;
    logic               dirty_q;
    logic [3:0]         status_q, status_set, status_clr;
    logic [METH_W-1:0]  meth_q;
    logic [SUBCH_W-1:0] subch_q;
    logic               wr_method, wr_data, wr_ctrl;
    logic               store_wr, ovf_evt, nocache_evt;
    logic               full_w, empty_w, pop_w, evt_miss, evt_sw;
    logic [PTR_W-1:0]   put_ptr_w, get_ptr_w;
    cmd_entry_t         head_w, disp_entry_w, new_entry;
    pull_ctrl_t         ctrl_w;

    assign wr_method   = bus_we && in_cmd_window(bus_addr) && !bus_addr[2];
    assign wr_data     = bus_we && in_cmd_window(bus_addr) &&  bus_addr[2];
    assign wr_ctrl     = bus_we && (bus_addr == REG_PULL_CTRL);
    assign nocache_evt = wr_data && !push_en_q;
    assign ovf_evt     = wr_data &&  push_en_q && full_w;
    assign store_wr    = wr_data &&  push_en_q && !full_w;

    assign new_entry.subch  = subch_q;
    assign new_entry.method = meth_q;
    assign new_entry.data   = bus_wdata;

    cf_cmd_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (store_wr),
        .wr_entry (new_entry),
        .rd_pop   (pop_w),
        .head     (head_w),
        .empty    (empty_w),
        .full     (full_w),
        .put_ptr  (put_ptr_w),
        .get_ptr  (get_ptr_w)
    );

    cf_puller u_puller (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (wr_ctrl),
        .ctrl_en_wr   (bus_wdata[CTRL_EN_BIT]),
        .ctrl_hash_wr (bus_wdata[CTRL_HASH_BIT]),
        .head         (head_w),
        .empty        (empty_w),
        .lookup_hit   (lookup_hit),
        .lookup_ctx   (lookup_ctx),
        .disp_ready   (disp_ready),
        .ctrl_q       (ctrl_w),
        .lookup_valid (lookup_valid),
        .pop          (pop_w),
        .evt_miss     (evt_miss),
        .evt_sw       (evt_sw),
        .disp_valid   (disp_valid),
        .disp_entry   (disp_entry_w),
        .disp_ctx     (disp_ctx)
    );

    assign lookup_name  = head_w.data;
    assign lookup_subch = head_w.subch;
    assign disp_subch   = disp_entry_w.subch;
    assign disp_method  = disp_entry_w.method;
    assign disp_data    = disp_entry_w.data;

    always_comb begin
        status_set = '0;
        status_set[STS_IRQ]     = evt_miss || evt_sw;
        status_set[STS_ERR]     = evt_miss;
        status_set[STS_OVF]     = ovf_evt;
        status_set[STS_NOCACHE] = nocache_evt;
        status_clr = (bus_we && bus_addr == REG_STATUS) ? bus_wdata[3:0] : 4'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_en_q <= 1'b0;
            dirty_q   <= 1'b0;
            status_q  <= '0;
            meth_q    <= '0;
            subch_q   <= '0;
        end else begin
            status_q <= (status_q & ~status_clr) | status_set;
            if (bus_we && bus_addr == REG_PUSH_EN)   push_en_q <= bus_wdata[0];
            if (bus_we && bus_addr == REG_CTX_STATE) dirty_q   <= bus_wdata[DIRTY_BIT];
            if (wr_method) begin
                meth_q  <= bus_wdata[METH_W-1:0] & METH_MASK;
                subch_q <= bus_wdata[15:13];
            end
        end
    end

    assign irq = status_q[STS_IRQ];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_PULL_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = ctrl_w.en;
                bus_rdata[CTRL_HASH_BIT] = ctrl_w.hash;
                bus_rdata[CTRL_SW_BIT]   = ctrl_w.sw;
            end
            REG_PUSH_EN:   bus_rdata[0] = push_en_q;
            REG_CTX_STATE: bus_rdata[DIRTY_BIT] = dirty_q;
            REG_STATUS:    bus_rdata[5:0] = {full_w, empty_w, status_q};
            REG_PUT:       bus_rdata[PTR_W+1:2] = put_ptr_w;
            REG_GET:       bus_rdata[PTR_W+1:2] = get_ptr_w;
            default:       bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cf_checker.sv
module cf_checker
    import cmdfifo_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic               irq,
    input logic               lookup_valid,
    input logic               lookup_hit,
    input logic [WORD_W-1:0]  lookup_ctx,
    input logic               disp_valid,
    input logic               disp_ready,
    input logic [WORD_W-1:0]  disp_data,
    input logic [METH_W-1:0]  disp_method,
    input logic               full_w,
    input logic               empty_w,
    input logic               pop_w,
    input logic               push_en_q,
    input logic [PTR_W-1:0]   put_ptr_w
);

    logic irq_clear;
    assign irq_clear = bus_we && (bus_addr == REG_STATUS) && bus_wdata[0];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        full_w && !pop_w |=> $stable(put_ptr_w));

    assert_push_gated_R4: assert property (@(posedge clk) disable iff (rst)
        !push_en_q |=> $stable(put_ptr_w));

    assert_empty_idle_R5: assert property (@(posedge clk) disable iff (rst)
        empty_w |-> !lookup_valid);

    assert_miss_halts_R6: assert property (@(posedge clk) disable iff (rst)
        lookup_valid && !lookup_hit |=> !lookup_valid && irq);

    assert_sw_halts_R7: assert property (@(posedge clk) disable iff (rst)
        lookup_valid && lookup_hit && !lookup_ctx[HW_CLASS_BIT] |=> !lookup_valid && irq);

    assert_disp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_data) && $stable(disp_method));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clear |=> irq);

endmodule

bind cmdfifo_top cf_checker #(.PTR_W(PTR_W)) u_cf_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq          (irq),
    .lookup_valid (lookup_valid),
    .lookup_hit   (lookup_hit),
    .lookup_ctx   (lookup_ctx),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .disp_data    (disp_data),
    .disp_method  (disp_method),
    .full_w       (full_w),
    .empty_w      (empty_w),
    .pop_w        (pop_w),
    .push_en_q    (push_en_q),
    .put_ptr_w    (put_ptr_w)
);

// File: tb/test_cmdfifo_top.sv
module test_cmdfifo_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lookup_valid;
    logic [31:0] lookup_name;
    logic [2:0]  lookup_subch;
    logic        lookup_hit = 1'b1;
    logic [31:0] lookup_ctx = 32'h0080_0000;
    logic        disp_valid;
    logic        disp_ready = 1'b1;
    logic [2:0]  disp_subch;
    logic [12:0] disp_method;
    logic [31:0] disp_data;
    logic [31:0] disp_ctx;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_got    = 0;
    logic [31:0] got_data [0:63];
    logic [12:0] got_meth [0:63];
    logic [2:0]  got_sub  [0:63];
    logic        seen_dead = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdfifo_top i_cmdfifo_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lookup_valid(lookup_valid), .lookup_name(lookup_name),
        .lookup_subch(lookup_subch), .lookup_hit(lookup_hit),
        .lookup_ctx(lookup_ctx), .disp_valid(disp_valid),
        .disp_ready(disp_ready), .disp_subch(disp_subch),
        .disp_method(disp_method), .disp_data(disp_data),
        .disp_ctx(disp_ctx), .irq(irq)
    );

    // accepted dispatches, sampled 1 time unit before each rising edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/2 - 1);
        if (!rst && disp_valid && disp_ready) begin
            if (n_got < 64) begin
                got_data[n_got] = disp_data;
                got_meth[n_got] = disp_method;
                got_sub[n_got]  = disp_subch;
            end
            if (disp_data == 32'h0000_DEAD) seen_dead = 1'b1;
            n_got++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push(input logic [2:0] sub, input logic [12:0] meth_raw, input logic [31:0] data);
        wr(8'h40, 32'hABCD_0000 | (32'(sub) << 13) | 32'(meth_raw));
        wr(8'h44, data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); check("R12 pull ctrl", v, 32'h0);
        rd(8'h04, v); check("R12 push access", v, 32'h0);
        rd(8'h0C, v); check("R12 status", v, 32'h10);
        rd(8'h10, v); check("R12 put", v, 32'h0);
        check("R12 irq", 32'(irq), 32'h0);
        check("R12 disp_valid", 32'(disp_valid), 32'h0);
    endtask

    task automatic t_nocache;
        logic [31:0] v;
        push(3'd1, 13'h0100, 32'hA1A1_A1A1);
        rd(8'h0C, v); check("R4 no-cache flag", v, 32'h18);
        rd(8'h10, v); check("R4 put unchanged", v, 32'h0);
        wr(8'h0C, 32'h8);
        rd(8'h0C, v); check("R9 W1C no-cache", v, 32'h10);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        wr(8'h04, 32'h1);
        lookup_hit = 1'b1; lookup_ctx = 32'h0080_0005; disp_ready = 1'b1;
        push(3'd3, 13'h0107, 32'h1111_1111);
        push(3'd7, 13'h1FFF, 32'h2222_2222);
        push(3'd0, 13'h0010, 32'h3333_3333);
        check("R5 no lookup while disabled", 32'(lookup_valid), 32'h0);
        rd(8'h10, v); check("R2 put count", v, 32'd12);
        rd(8'h0C, v); check("R3 not empty", v, 32'h0);
        check("R5 nothing dispatched", 32'(n_got), 32'd0);
        wr(8'h00, 32'h1);
        idle(6);
        check("R2 count drained", 32'(n_got), 32'd3);
        check("R1 data 0", got_data[0], 32'h1111_1111);
        check("R1 method 0", 32'(got_meth[0]), 32'h0104);
        check("R1 subch 0", 32'(got_sub[0]), 32'd3);
        check("R1 method 1", 32'(got_meth[1]), 32'h1FFC);
        check("R1 subch 1", 32'(got_sub[1]), 32'd7);
        check("R2 order data 2", got_data[2], 32'h3333_3333);
        check("R1 method 2", 32'(got_meth[2]), 32'h0010);
        rd(8'h14, v); check("R2 get count", v, 32'd12);
        rd(8'h00, v); check("R8 ctrl after hw", v, 32'h1);
        rd(8'h0C, v); check("R3 empty again", v, 32'h10);
    endtask

    task automatic t_backpressure;
        disp_ready = 1'b0;
        push(3'd2, 13'h0200, 32'h4444_4444);
        idle(3);
        check("R8 valid under stall", 32'(disp_valid), 32'h1);
        check("R8 data under stall", disp_data, 32'h4444_4444);
        check("R8 ctx carried", disp_ctx, 32'h0080_0005);
        idle(2);
        check("R8 data held", disp_data, 32'h4444_4444);
        check("R8 not taken yet", 32'(n_got), 32'd3);
        disp_ready = 1'b1;
        idle(3);
        check("R8 taken", 32'(n_got), 32'd4);
        check("R8 valid dropped", 32'(disp_valid), 32'h0);
    endtask

    task automatic t_miss;
        logic [31:0] v;
        lookup_hit = 1'b0;
        push(3'd5, 13'h0300, 32'h5555_5555);
        idle(4);
        rd(8'h00, v); check("R6 ctrl after miss", v, 32'h10);
        rd(8'h0C, v); check("R6 status after miss", v, 32'h03);
        check("R6 irq", 32'(irq), 32'h1);
        check("R6 not dispatched", 32'(n_got), 32'd4);
        wr(8'h0C, 32'h2);
        check("R9 irq kept on partial clear", 32'(irq), 32'h1);
        wr(8'h0C, 32'h1);
        check("R9 irq cleared", 32'(irq), 32'h0);
        lookup_hit = 1'b1; lookup_ctx = 32'h0080_0007;
        wr(8'h00, 32'h1);
        idle(4);
        check("R6 resumed dispatch", 32'(n_got), 32'd5);
        check("R6 resumed data", got_data[4], 32'h5555_5555);
        rd(8'h00, v); check("R6 hash cleared on hit", v, 32'h1);
    endtask

    task automatic t_software;
        logic [31:0] v;
        lookup_ctx = 32'h0000_0042;
        push(3'd6, 13'h0400, 32'h6666_6666);
        idle(4);
        rd(8'h00, v); check("R7 ctrl after sw", v, 32'h100);
        check("R7 irq", 32'(irq), 32'h1);
        check("R7 not dispatched", 32'(n_got), 32'd5);
        wr(8'h00, 32'h10);
        rd(8'h00, v); check("R11 bit4 written, bit8 kept", v, 32'h110);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R11 bit8 survives write", v, 32'h100);
        lookup_ctx = 32'h0080_0042;
        wr(8'h00, 32'h1);
        idle(4);
        rd(8'h00, v); check("R8 sw cleared on hw hit", v, 32'h1);
        check("R7 resumed dispatch", 32'(n_got), 32'd6);
        wr(8'h0C, 32'hF);
        check("R9 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_ctx_state;
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); check("R10 dirty set", v, 32'h10);
        wr(8'h08, 32'hFFFF_FFEF);
        rd(8'h08, v); check("R10 dirty clear", v, 32'h0);
    endtask

    task automatic t_full;
        logic [31:0] v;
        wr(8'h00, 32'h0);
        for (int i = 0; i < 31; i++) push(3'(i), 13'(i * 4), 32'h7000_0000 + 32'(i));
        rd(8'h0C, v); check("R3 full flag", v, 32'h20);
        rd(8'h10, v); check("R3 put at wrap", v, 32'h14);
        push(3'd1, 13'h0004, 32'h0000_DEAD);
        rd(8'h0C, v); check("R3 overflow flag", v, 32'h24);
        rd(8'h10, v); check("R3 put unchanged on drop", v, 32'h14);
        lookup_hit = 1'b1; lookup_ctx = 32'h0080_0000; disp_ready = 1'b1;
        wr(8'h00, 32'h1);
        idle(40);
        check("R3 drained count", 32'(n_got), 32'd37);
        check("R2 last entry", got_data[36], 32'h7000_001E);
        check("R2 first after wrap", got_data[6], 32'h7000_0000);
        check("R3 dropped entry absent", 32'(seen_dead), 32'h0);
        rd(8'h14, v); check("R2 get at wrap", v, 32'h14);
        rd(8'h0C, v); check("R3 empty with overflow", v, 32'h14);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nocache();
        t_basic();
        t_backpressure();
        t_miss();
        t_software();
        t_ctx_state();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule